// File: doc/BRIEF.md
# Display Memory Address Counter

This block gives a host access to the 512-byte dot memory of a graphic panel column driver. Each stored bit is one dot: a 1 lights the dot and a 0 leaves it dark. The host points into the memory with two separate load operations. One loads a 3-bit page register. The other loads a 6-bit column counter. The page and column together form a 9-bit byte address, with the page in the upper 3 bits and the column in the lower 6 bits.

Data reads and data writes use the byte at the current address. After each access the column counter steps forward by one and wraps from 63 back to 0. The page never counts. It changes only when the host loads it.

A strap input decides whether columns map straight or mirrored. The strap is captured only while reset is held. In mirrored mode the column that reaches the memory is 63 minus the counter value. The host interface is a set of single-cycle strobes sharing one data bus. Read data comes back on the cycle after the read strobe.

Top module: `pixmem_addr_unit`

## Requirements
- R1: From the first idle cycle after reset release, the page and column are 0. `mem_addr` shows 0 in straight mode and 63 in mirrored mode, and `dout_vld` is low.
- R2: A cycle with `page_ld` high loads the page from `din[2:0]` and ignores `din[7:3]`. In every other cycle the page keeps its value, including cycles with a data access.
- R3: A cycle with `col_ld` high loads the column from `din[5:0]` and ignores `din[7:6]`. A column load takes priority over the auto-step of an access in the same cycle.
- R4: Each cycle with `wr_stb` or `rd_stb` high, and no column load, advances the column by exactly one, wrapping from 63 to 0.
- R5: `wr_stb` stores `din` at the current effective address. `rd_stb` returns the byte at the current effective address on `dout`, with `dout_vld` high, in the following cycle. `dout` holds between reads. `wr_stb` and `rd_stb` are never high in the same cycle.
- R6: `mem_addr` is {page, column} when the strap was 0 at reset and {page, 63 - column} when it was 1. Memory accesses use `mem_addr`. Changing the strap outside reset has no effect.
- R7: When `page_ld` coincides with a data access, the access uses the old page, the column still advances, and the new page applies from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mirror_strap | input | 1 | Column mirror select, captured while reset is held |
| page_ld | input | 1 | Load the page register from din |
| col_ld | input | 1 | Load the column counter from din |
| wr_stb | input | 1 | Write din at the current address and advance the column |
| rd_stb | input | 1 | Read the current address and advance the column |
| din | input | 8 | Shared bus for load values and write data |
| dout | output | 8 | Read data, updated the cycle after rd_stb |
| dout_vld | output | 1 | High for one cycle when dout carries new read data |
| mem_addr | output | 9 | Effective memory address currently pointed at |

## Verification
Two loads can fall in the same cycle as the column auto-step: a page load together with a data access, and a column load together with a data access. The bench raises these strobe pairs in the same cycle, both in directed steps and at random. The behavioural model advances the column and applies the access at the pre-edge page, while a column load overrides the step. The model's `mem_addr`, `dout_vld` and `dout` are compared on every clock, so a wrong priority or a wrong address for the access shows up either at once or on a later read-back.

// File: rtl/pixmem_pkg.sv
package pixmem_pkg;
  localparam int PAGE_W_DEF = 3;
  localparam int COL_W_DEF  = 6;
  localparam int DATA_W_DEF = 8;

  typedef enum logic [1:0] {
    ACC_NONE  = 2'b00,
    ACC_WRITE = 2'b01,
    ACC_READ  = 2'b10
  } acc_e;

  function automatic acc_e acc_kind(input logic we, input logic re);
    if (we)      return ACC_WRITE;
    else if (re) return ACC_READ;
    else         return ACC_NONE;
  endfunction
endpackage

// File: rtl/pixmem_rst_sync.sv
module pixmem_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/pixmem_addr_ctr.sv
module pixmem_addr_ctr #(
  parameter int PAGE_W = 3,
  parameter int COL_W  = 6,
  localparam int ADDR_W = PAGE_W + COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strap,
  input  logic              page_ld,
  input  logic              col_ld,
  input  logic              advance,
  input  logic [PAGE_W-1:0] page_val,
  input  logic [COL_W-1:0]  col_val,
  output logic [ADDR_W-1:0] eff_addr
);
  logic              mirror_q;
  logic [PAGE_W-1:0] page_q, page_d;
  logic [COL_W-1:0]  col_q, col_d;
  logic [COL_W-1:0]  col_eff;

  // strap is captured only while reset is held
  always_ff @(posedge clk) begin
    if (!rst_n) mirror_q <= strap;
  end

  always_comb begin
    page_d = page_q;
    if (page_ld) page_d = page_val;
  end

  always_comb begin
    col_d = col_q;
    if (col_ld)       col_d = col_val;
    else if (advance) col_d = col_q + COL_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q <= '0;
      col_q  <= '0;
    end else begin
      page_q <= page_d;
      col_q  <= col_d;
    end
  end

  // mirrored column: (2^COL_W - 1) - col is a bitwise inversion
  for (genvar b = 0; b < COL_W; b++) begin : g_mirror
    assign col_eff[b] = col_q[b] ^ mirror_q;
  end

  assign eff_addr = {page_q, col_eff};

  assert_page_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !page_ld |=> $stable(page_q));
  assert_col_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    col_ld |=> col_q == $past(col_val));
  assert_col_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !col_ld) |=> col_q == COL_W'($past(col_q) + COL_W'(1)));
  assert_col_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !col_ld && col_q == '1) |=> col_q == '0);
  assert_strap_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(mirror_q));
  assert_page_with_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (page_ld && advance && !col_ld) |=>
      (page_q == $past(page_val)) && (col_q == COL_W'($past(col_q) + COL_W'(1))));
endmodule

// File: rtl/pixmem_store.sv
module pixmem_store
  import pixmem_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 8,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic              re,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);
  logic [DATA_W-1:0] cells [DEPTH];
  acc_e              kind;
  logic              rvalid_d;

  always_comb begin
    kind     = acc_kind(we, re);
    rvalid_d = (kind == ACC_READ);
  end

  always_ff @(posedge clk) begin
    if (kind == ACC_WRITE) cells[addr] <= wdata;
    if (kind == ACC_READ)  rdata <= cells[addr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rvalid <= 1'b0;
    else        rvalid <= rvalid_d;
  end

  assert_no_rw_overlap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(we && re));
  assert_rvalid_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
    re |=> rvalid);
  assert_rvalid_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !re |=> !rvalid);
endmodule

// File: rtl/pixmem_addr_unit.sv
module pixmem_addr_unit
  import pixmem_pkg::*;
#(
  parameter int PAGE_W = PAGE_W_DEF,
  parameter int COL_W  = COL_W_DEF,
  parameter int DATA_W = DATA_W_DEF,
  localparam int ADDR_W = PAGE_W + COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mirror_strap,
  input  logic              page_ld,
  input  logic              col_ld,
  input  logic              wr_stb,
  input  logic              rd_stb,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              dout_vld,
  output logic [ADDR_W-1:0] mem_addr
);
  logic rst_ns;
  logic advance;
  logic unused_din_hi;

  assign advance       = wr_stb | rd_stb;
  assign unused_din_hi = ^din[DATA_W-1:COL_W];

  pixmem_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_ns)
  );

  pixmem_addr_ctr #(.PAGE_W(PAGE_W), .COL_W(COL_W)) u_ctr (
    .clk      (clk),
    .rst_n    (rst_ns),
    .strap    (mirror_strap),
    .page_ld  (page_ld),
    .col_ld   (col_ld),
    .advance  (advance),
    .page_val (din[PAGE_W-1:0]),
    .col_val  (din[COL_W-1:0]),
    .eff_addr (mem_addr)
  );

  pixmem_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk    (clk),
    .rst_n  (rst_ns),
    .we     (wr_stb),
    .re     (rd_stb),
    .addr   (mem_addr),
    .wdata  (din),
    .rdata  (dout),
    .rvalid (dout_vld)
  );
endmodule

// File: tb/pixmem_addr_unit_test.sv
`timescale 1ns/1ps
module pixmem_addr_unit_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       strap = 1'b0;
  logic       page_ld = 1'b0, col_ld = 1'b0, wr_stb = 1'b0, rd_stb = 1'b0;
  logic [7:0] din = '0;
  logic [7:0] dout;
  logic       dout_vld;
  logic [8:0] mem_addr;

  int vecs = 0;
  int fails = 0;
  bit done = 0;

  // behavioural reference
  int   m_page = 0, m_col = 0, m_mirror = 0;
  bit   m_vld = 0, m_known = 0;
  int   m_dout = 0;
  logic [7:0] m_mem [int];

  always #4 clk = ~clk;

  pixmem_addr_unit uut (
    .clk(clk), .rst_n(rst_n), .mirror_strap(strap),
    .page_ld(page_ld), .col_ld(col_ld), .wr_stb(wr_stb), .rd_stb(rd_stb),
    .din(din), .dout(dout), .dout_vld(dout_vld), .mem_addr(mem_addr)
  );

  function automatic int eff_addr_m();
    return m_page * 64 + (m_mirror != 0 ? 63 - m_col : m_col);
  endfunction

  task automatic compare(input string tag);
    int ea;
    ea = eff_addr_m();
    vecs++;
    if (mem_addr !== 9'(ea)) begin
      fails++;
      $display("FAIL %s mem_addr actual %0d expected %0d", tag, mem_addr, ea);
    end
    if (dout_vld !== m_vld) begin
      fails++;
      $display("FAIL %s dout_vld actual %0b expected %0b", tag, dout_vld, m_vld);
    end
    if (m_known && dout !== 8'(m_dout)) begin
      fails++;
      $display("FAIL %s dout actual %02h expected %02h", tag, dout, m_dout);
    end
  endtask

  task automatic step(input bit pl, input bit cl, input bit wr, input bit rd,
                      input logic [7:0] d, input string tag);
    int ea;
    page_ld = pl; col_ld = cl; wr_stb = wr; rd_stb = rd; din = d;
    @(posedge clk);
    ea = eff_addr_m();
    if (wr) m_mem[ea] = d;
    m_vld = rd;
    if (rd) begin
      if (m_mem.exists(ea)) begin m_known = 1; m_dout = m_mem[ea]; end
      else m_known = 0;
    end
    if (pl) m_page = d % 8;
    if (cl) m_col = d % 64;
    else if (wr || rd) m_col = (m_col + 1) % 64;
    @(negedge clk);
    compare(tag);
  endtask

  task automatic do_reset(input bit s);
    @(negedge clk);
    rst_n = 1'b0; strap = s;
    page_ld = 0; col_ld = 0; wr_stb = 0; rd_stb = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    m_page = 0; m_col = 0; m_mirror = s; m_vld = 0;
    compare("R1");
  endtask

  initial begin
    do_reset(1'b0);
    step(0, 0, 0, 0, 8'h00, "R1");

    // loads, upper din bits ignored
    step(1, 0, 0, 0, 8'hFD, "R2");
    step(0, 1, 0, 0, 8'hFC, "R3");
    // writes across the 63 -> 0 wrap, page untouched
    for (int i = 0; i < 6; i++) step(0, 0, 1, 0, 8'(8'h30 + i), "R4");
    // read back the same bytes
    step(0, 1, 0, 0, 8'h3C, "R3");
    for (int i = 0; i < 6; i++) step(0, 0, 0, 1, 8'h00, "R5");
    step(0, 0, 0, 0, 8'h00, "R5");
    // page load in the same cycle as a write
    step(0, 1, 0, 0, 8'h0A, "R3");
    step(1, 0, 1, 0, 8'h02, "R7");
    step(1, 0, 0, 1, 8'h07, "R7");
    step(1, 0, 0, 0, 8'h05, "R2");
    step(0, 1, 0, 0, 8'h0A, "R3");
    step(0, 0, 0, 1, 8'h00, "R7");
    // column load wins over the step
    step(0, 1, 1, 0, 8'h14, "R3");
    step(0, 1, 0, 1, 8'h3C, "R3");

    // mixed traffic
    void'($urandom(7));
    for (int i = 0; i < 400; i++) begin
      int op;
      logic [7:0] d;
      op = $urandom % 7;
      d  = 8'($urandom);
      case (op)
        0: step(1, 0, 0, 0, d, "R2");
        1: step(0, 1, 0, 0, d, "R3");
        2, 3: step(0, 0, 1, 0, d, "R4");
        4: step(0, 0, 0, 1, d, "R5");
        5: step(1, 0, 1, 0, d, "R7");
        default: step(0, 1, 0, 1, d, "R3");
      endcase
    end

    // mirrored mode
    do_reset(1'b1);
    strap = 1'b0;
    step(0, 0, 0, 0, 8'h00, "R6");
    step(1, 0, 0, 0, 8'h05, "R6");
    step(0, 1, 0, 0, 8'h03, "R6");
    step(0, 0, 0, 1, 8'h00, "R6");
    step(0, 1, 0, 0, 8'h3E, "R6");
    for (int i = 0; i < 4; i++) step(0, 0, 1, 0, 8'(8'hA0 + i), "R6");
    step(0, 1, 0, 0, 8'h3E, "R6");
    for (int i = 0; i < 4; i++) step(0, 0, 0, 1, 8'h00, "R6");
    for (int i = 0; i < 300; i++) begin
      int op;
      logic [7:0] d;
      op = $urandom % 5;
      d  = 8'($urandom);
      case (op)
        0: step(1, 0, 0, 0, d, "R6");
        1: step(0, 1, 0, 0, d, "R6");
        2: step(0, 0, 1, 0, d, "R6");
        3: step(0, 0, 0, 1, d, "R6");
        default: step(1, 0, 0, 1, d, "R7");
      endcase
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R1 watchdog actual %0d cycles expected completion", 200000);
      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
    end
  end
endmodule